// File: doc/BRIEF.md
# Grouped Pin-Toggle Interrupt Controller

This block watches sixteen general-purpose input pins for any logic transition and turns them into two interrupt requests. Pins 7..0 form group 0 and pins 15..8 form group 1. Each pin first passes through a two-flop synchroniser. A change is found by comparing the synchronised value with its value one cycle earlier. A per-pin mask bit decides whether that change counts toward its group. Any counted change, rising or falling, sets a single sticky flag for the group.

Each group's request line is raised while three things are true at once: its flag is set, its group enable is one, and the global interrupt-enable input is one. Software clears a flag by writing a one to it. The interrupt sequencer clears it by pulsing the group's acknowledge input when it takes that group's vector. If a new change arrives in the same cycle as a clear, the flag stays set, so no toggle is lost.

Software reaches the block through four 8-bit registers on a 2-bit address, with single-cycle write strobes and combinational read data. Address 0 is the group enables, address 1 is the flags, and addresses 2 and 3 are the masks for groups 0 and 1. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `pin_toggle_irq`

## Requirements
- R1: After reset, all four registers read zero and both request lines are low.
- R2: Writes are captured on the clock edge on which `wr_en_i` is high. The mask registers (address 2 for pins 7..0, address 3 for pins 15..8, bit n = pin n within the group) and enable bits 1..0 at address 0 (bit g = group g) read back what was written.
- R3: Bits 7..2 of addresses 0 and 1 always read zero, whatever was written there.
- R4: A rising or a falling change on a masked-in pin sets its group's flag: bit 0 of address 1 for group 0, bit 1 for group 1. The flag reads set from the third rising edge after the pin changes, and it stays set until it is cleared.
- R5: A change on a pin whose mask bit is zero leaves the flags unchanged.
- R6: A flag is set by a counted change even while its group enable is zero.
- R7: `irq_o[g]` is high exactly when flag g, enable bit g and `gie_i` are all one.
- R8: Writing address 1 clears each flag whose data bit is one. A flag whose data bit is zero is unchanged.
- R9: A pulse on `ack_i[g]` clears flag g at the next edge and leaves the other group's flag alone.
- R10: When a counted change and a clear (a one written to the flag, or an acknowledge) act on the same edge, the flag ends up set.
- R11: The two groups are independent. A change counted in one group never sets the other group's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 16 | Asynchronous pin levels; bits 7..0 are group 0, bits 15..8 are group 1 |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 2 | Vector-taken acknowledge, one bit per group |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| addr_i | input | 2 | Register select: 0 enables, 1 flags, 2 mask group 0, 3 mask group 1 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| irq_o | output | 2 | Interrupt request, one per group |

## Verification
On every cycle, the assertions check the flag rules for each group:
- a flag never rises without a counted change;
- a set flag holds until it is cleared;
- a clear with no new change drops the flag;
- a counted change always leaves the flag set, even against a clear (R10);
- a request never appears without the global enable and the group enable;
- the reserved read bits stay zero.

Only the bench's scenarios show the rest:
- the three-edge latency from a pin to its flag;
- that masked-out pins and the other group are ignored;
- the exact moment when a clear collides with a change;
- that register values read back as written.

// File: rtl/pti_pkg.sv
package pti_pkg;
  localparam int GROUPS     = 2;
  localparam int GRP_W      = 8;
  localparam int PINS       = GROUPS * GRP_W;
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 2;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE = 2'd0,
    REG_FLAGS  = 2'd1,
    REG_MASK0  = 2'd2,
    REG_MASK1  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pti_sync.sv
module pti_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] chg_o
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[LAST];
  end

  assign chg_o = stage_q[LAST] ^ prev_q;
endmodule

// File: rtl/pti_group.sv
module pti_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] chg_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wd_i,
  input  logic         w1c_i,
  input  logic         ack_i,
  input  logic         en_i,
  input  logic         gie_i,
  output logic [W-1:0] mask_o,
  output logic         flag_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         flag_q;
  logic         hit;
  logic         clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wd_i;
  end

  assign hit = |(chg_i & mask_q);
  assign clr = w1c_i | ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i & gie_i;

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q) else $error("R10: counted change did not leave flag set");
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_q) else $error("R8/R9: clear did not drop flag");
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q) else $error("R4: flag dropped without clear");
  p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit)) else $error("R5: flag rose without counted change");
endmodule

// File: rtl/pin_toggle_irq.sv
module pin_toggle_irq
  import pti_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PINS-1:0]      pins_i,
  input  logic                 gie_i,
  input  logic [GROUPS-1:0]    ack_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic [GROUPS-1:0]    irq_o
);
  localparam int PAD = REG_W - GROUPS;

  logic [GROUPS-1:0] en_q;
  logic [GROUPS-1:0] flags;
  logic [PINS-1:0]   chg;
  logic [GRP_W-1:0]  mask [GROUPS];
  reg_sel_e          sel;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             en_q <= '0;
    else if (wr_en_i && sel == REG_ENABLE)  en_q <= wdata_i[GROUPS-1:0];
  end

  pti_sync #(.W(PINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (pins_i),
    .chg_o (chg)
  );

  genvar g;
  generate
    for (g = 0; g < GROUPS; g++) begin : g_grp
      logic mask_we;
      logic w1c;
      assign mask_we = wr_en_i && (addr_i == ADDR_W'(REG_MASK0) + ADDR_W'(g));
      assign w1c     = wr_en_i && (sel == REG_FLAGS) && wdata_i[g];

      pti_group #(.W(GRP_W)) u_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg_i     (chg[g*GRP_W +: GRP_W]),
        .mask_we_i (mask_we),
        .mask_wd_i (wdata_i[GRP_W-1:0]),
        .w1c_i     (w1c),
        .ack_i     (ack_i[g]),
        .en_i      (en_q[g]),
        .gie_i     (gie_i),
        .mask_o    (mask[g]),
        .flag_o    (flags[g]),
        .irq_o     (irq_o[g])
      );

      p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[g] |-> (gie_i && en_q[g])) else $error("R7: request without enables");
    end
  endgenerate

  always_comb begin
    unique case (sel)
      REG_ENABLE: rdata_o = {{PAD{1'b0}}, en_q};
      REG_FLAGS:  rdata_o = {{PAD{1'b0}}, flags};
      REG_MASK0:  rdata_o = REG_W'(mask[0]);
      REG_MASK1:  rdata_o = REG_W'(mask[1]);
      default:    rdata_o = '0;
    endcase
  end

  always_comb begin
    if (rst_n && (sel == REG_ENABLE || sel == REG_FLAGS))
      p_reserved_r3: assert (rdata_o[REG_W-1:GROUPS] == '0) else $error("R3: reserved bits nonzero");
  end
endmodule

// File: tb/pin_toggle_irq_bench.sv
module pin_toggle_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pins = '0;
  logic        gie = 1'b0;
  logic [1:0]  ack = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pin_toggle_irq u_pin_toggle_irq (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .gie_i(gie), .ack_i(ack),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {pin levels, expected flags}; masks: group0 = 0x0F, group1 = 0xF0 (pins 15..12)
  localparam logic [17:0] VEC [8] = '{
    {16'h0001, 2'b01},  // R4 rising on pin 0
    {16'h0000, 2'b01},  // R4 falling on pin 0
    {16'h0010, 2'b00},  // R5 pin 4 masked out
    {16'h1010, 2'b10},  // R11 pin 12 only group 1
    {16'h0110, 2'b10},  // R5 pin 8 ignored, pin 12 falls
    {16'h0118, 2'b01},  // R11 pin 3 only group 0
    {16'h F11F, 2'b11},
    {16'hF11F, 2'b00}   // no change
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v); check("R1", v, 8'h00);
    end
    check("R1 irq", {6'b0, irq}, 8'h00);

    // R2 / R3 register access
    wr_reg(2'd2, 8'h0F); wr_reg(2'd3, 8'hF0); wr_reg(2'd0, 8'hFC);
    rd_reg(2'd2, v); check("R2 mask0", v, 8'h0F);
    rd_reg(2'd3, v); check("R2 mask1", v, 8'hF0);
    rd_reg(2'd0, v); check("R3 enable reserved", v, 8'h00);
    wr_reg(2'd1, 8'hFC);
    rd_reg(2'd1, v); check("R3 flag reserved", v, 8'h00);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); pins = VEC[i][17:2];
      settle();
      rd_reg(2'd1, v); check("R4/R5/R11 table", v, {6'b0, VEC[i][1:0]});
      wr_reg(2'd1, 8'h03);
    end
    rd_reg(2'd1, v); check("R8 cleared after table", v, 8'h00);

    // R4 latency: flag reads set exactly after the third edge
    @(negedge clk); pins[0] = ~pins[0]; addr = 2'd1;
    @(posedge clk); @(posedge clk); #1;
    check("R4 not before third edge", rdata, 8'h00);
    @(posedge clk); #1;
    check("R4 third edge", rdata, 8'h01);

    // R6 / R7
    @(negedge clk); gie = 1'b1; #1;
    check("R6/R7 enable off", {6'b0, irq}, 8'h00);
    wr_reg(2'd0, 8'h01); #1;
    check("R7 both enables", {6'b0, irq}, 8'h01);
    @(negedge clk); gie = 1'b0; #1;
    check("R7 gie low", {6'b0, irq}, 8'h00);

    // R8 write zero keeps, write one clears
    wr_reg(2'd1, 8'h02);
    rd_reg(2'd1, v); check("R8 write zero", v, 8'h01);
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd1, v); check("R8 write one", v, 8'h00);

    // R9 ack clears only its group
    @(negedge clk); pins[15] = ~pins[15]; pins[1] = ~pins[1];
    settle();
    rd_reg(2'd1, v); check("R11 both set", v, 8'h03);
    @(negedge clk); ack = 2'b10;
    @(negedge clk); ack = 2'b00;
    rd_reg(2'd1, v); check("R9 ack group1", v, 8'h01);

    // R10 set wins over write-one-clear on the same edge
    @(negedge clk); pins[2] = ~pins[2];
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr = 1'b1; addr = 2'd1; wdata = 8'h01;
    @(negedge clk); wr = 1'b0;
    rd_reg(2'd1, v); check("R10 vs w1c", v, 8'h01);

    // R10 set wins over ack on the same edge
    @(negedge clk); pins[3] = ~pins[3];
    @(posedge clk); @(posedge clk);
    @(negedge clk); ack = 2'b01;
    @(negedge clk); ack = 2'b00;
    rd_reg(2'd1, v); check("R10 vs ack", v, 8'h01);
    @(negedge clk); ack = 2'b01;
    @(negedge clk); ack = 2'b00;
    rd_reg(2'd1, v); check("R9 ack group0", v, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule